// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the processor's privileged control registers and answers the two instructions that move data between them and the general registers. A request carries an operation (read, write or exception return), a 5-bit control register index, the write data and the general-register destination number of a read. Each accepted request yields exactly one response that carries the read data, a write-back enable for the general register file and a privilege-fault flag.

Requests and responses use valid/ready handshakes. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the one-entry response slot is empty or is being emptied in the same cycle. The response stays on its pins, unchanged, until `rsp_ready` accepts it. A consumer that holds `rsp_ready` low stalls the request side after one response.

The pending-interrupt value is not stored. It is formed from the external interrupt lines masked by the enable register. The interrupt request output combines that value with the global enable bit of the status register. A write to the status or enable register produces a one-cycle update pulse so the core re-evaluates interrupts at once.

Top module: `ctl_regfile`

## Requirements
- R1: After reset every stored control register is zero, `rsp_valid`, `irq_req` and `status_upd` are low and `req_ready` is high.
- R2: Operation code 0 reads and code 1 writes. A supervisor-mode write to a storable index (0,1,2,3,7,8,9,10,12,13,14,15) is returned by any later read of that index. A write response carries data 0, `rsp_wb` 0 and `rsp_fault` 0.
- R3: A read of index 4 returns `irq_lines & ienable`, where ienable is index 3. A write to index 4 changes nothing.
- R4: A read of index 5 returns the `CPU_ID` parameter, and a write to it changes nothing. Indices 6, 11 and 16 to 31 read as zero and ignore writes.
- R5: A read or write accepted while `user_mode` is high responds with `rsp_fault` 1, data 0 and `rsp_wb` 0, and changes no register.
- R6: `status_upd` is high for exactly the cycle after an accepted supervisor write to index 0 or index 3, and is low at all other times.
- R7: Operation code 2 (exception return) copies index 1 into index 0 and gives a response with data 0, `rsp_wb` 0 and `rsp_fault` 0. Code 3 gives the same empty response and changes nothing.
- R8: `irq_req` is high exactly when `irq_lines & ienable` is nonzero and bit 0 of status (index 0) is set.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response pins hold their values.
- R10: A successful read sets `rsp_wb` to 1 only when `req_dest` is nonzero. With `req_dest` 0 it still returns the data with `rsp_wb` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge when valid |
| req_op | input | 2 | 0 read, 1 write, 2 exception return, 3 empty |
| req_idx | input | IDX_W | Control register index |
| req_dest | input | DEST_W | General-register destination of a read |
| req_wdata | input | DATA_W | Write data |
| user_mode | input | 1 | High when the core runs in user mode |
| irq_lines | input | DATA_W | External interrupt lines |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Read data |
| rsp_wb | output | 1 | General-register write-back enable |
| rsp_fault | output | 1 | Supervisor-only violation |
| irq_req | output | 1 | Interrupt request to the core |
| status_upd | output | 1 | One-cycle pulse after a status or enable write |

## Verification
The read path is tried with stored registers that hold distinct patterns, with the synthesised pending index under interrupt lines that fall inside and outside the enable mask, and with the constant and reserved indices. These reads tell storage, masking and fixed values apart. Writes are sent in both privilege modes and to read-only and reserved indices, and each is followed by reads. This shows that only a supervisor write to a storable index changes anything. The interrupt request is observed while the lines, the enable mask and the global enable bit toggle one at a time. An exception return is issued after estatus is loaded with a value that differs from status. A phase in which the consumer often withholds `rsp_ready` confirms that responses arrive in order and stay stable while stalled.

// File: rtl/ctlrf_pkg.sv
package ctlrf_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERET  = 2'd2,
    OP_NONE  = 2'd3
  } ctl_op_e;

  localparam int IX_STATUS  = 0;
  localparam int IX_ESTATUS = 1;
  localparam int IX_IENABLE = 3;
  localparam int IX_IPEND   = 4;
  localparam int IX_CPUID   = 5;

  // Indices backed by a flip-flop register.
  function automatic logic storable(int ix);
    case (ix)
      0, 1, 2, 3, 7, 8, 9, 10, 12, 13, 14, 15: return 1'b1;
      default:                                 return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ctlrf_access.sv
module ctlrf_access
  import ctlrf_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             accept,
  input  ctl_op_e          op,
  input  logic [IDX_W-1:0] idx,
  input  logic             user_mode,
  output logic             rd_ok,
  output logic             wr_ok,
  output logic             eret_ok,
  output logic             fault,
  output logic             upd_hit
);
  localparam logic [IDX_W-1:0] S_STATUS = IDX_W'(IX_STATUS);
  localparam logic [IDX_W-1:0] S_IEN    = IDX_W'(IX_IENABLE);

  logic priv_op;

  always_comb begin
    priv_op = (op == OP_READ) || (op == OP_WRITE);
    fault   = priv_op && user_mode;
    rd_ok   = accept && (op == OP_READ)  && !user_mode;
    wr_ok   = accept && (op == OP_WRITE) && !user_mode;
    eret_ok = accept && (op == OP_ERET);
    upd_hit = wr_ok && ((idx == S_STATUS) || (idx == S_IEN));
  end
endmodule

// File: rtl/ctlrf_bank.sv
module ctlrf_bank
  import ctlrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eret,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] ienable_q
);
  localparam int NREG = 1 << IDX_W;

  logic [NREG-1:0][DATA_W-1:0] regs;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    if (storable(i)) begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= '0;
        else if (wr_en && (wr_idx == IDX_W'(i)))
          q <= wr_data;
        else if ((i == IX_STATUS) && eret)
          q <= regs[IX_ESTATUS];
      end
      assign regs[i] = q;
    end else begin : g_hole
      assign regs[i] = '0;
    end
  end

  assign rd_data   = regs[rd_idx];
  assign status_q  = regs[IX_STATUS];
  assign ienable_q = regs[IX_IENABLE];

  assert_eret_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !wr_en) |=> (regs[IX_STATUS] == $past(regs[IX_ESTATUS])));
endmodule

// File: rtl/ctlrf_irq.sv
module ctlrf_irq #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] irq_lines,
  input  logic [DATA_W-1:0] ienable,
  input  logic              glob_en,
  output logic [DATA_W-1:0] pending,
  output logic              irq_req
);
  always_comb begin
    pending = irq_lines & ienable;
    irq_req = glob_en && (|pending);
  end
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import ctlrf_pkg::*;
#(
  parameter int                DATA_W = 32,
  parameter int                IDX_W  = 5,
  parameter int                DEST_W = 5,
  parameter logic [DATA_W-1:0] CPU_ID = DATA_W'(32'h0C1D_0042)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DEST_W-1:0] req_dest,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              user_mode,
  input  logic [DATA_W-1:0] irq_lines,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_wb,
  output logic              rsp_fault,
  output logic              irq_req,
  output logic              status_upd
);
  localparam logic [IDX_W-1:0] S_IPEND = IDX_W'(IX_IPEND);
  localparam logic [IDX_W-1:0] S_CPUID = IDX_W'(IX_CPUID);

  ctl_op_e           op_e;
  logic              accept;
  logic              rd_ok, wr_ok, eret_ok, fault, upd_hit;
  logic [DATA_W-1:0] bank_rd, status_q, ienable_q, pending, rd_val;

  assign op_e      = ctl_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  ctlrf_access #(.IDX_W(IDX_W)) u_access (
    .accept   (accept),
    .op       (op_e),
    .idx      (req_idx),
    .user_mode(user_mode),
    .rd_ok    (rd_ok),
    .wr_ok    (wr_ok),
    .eret_ok  (eret_ok),
    .fault    (fault),
    .upd_hit  (upd_hit)
  );

  ctlrf_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ok),
    .wr_idx   (req_idx),
    .wr_data  (req_wdata),
    .eret     (eret_ok),
    .rd_idx   (req_idx),
    .rd_data  (bank_rd),
    .status_q (status_q),
    .ienable_q(ienable_q)
  );

  ctlrf_irq #(.DATA_W(DATA_W)) u_irq (
    .irq_lines(irq_lines),
    .ienable  (ienable_q),
    .glob_en  (status_q[0]),
    .pending  (pending),
    .irq_req  (irq_req)
  );

  always_comb begin
    case (req_idx)
      S_IPEND: rd_val = pending;
      S_CPUID: rd_val = CPU_ID;
      default: rd_val = bank_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_wb     <= 1'b0;
      rsp_fault  <= 1'b0;
      status_upd <= 1'b0;
    end else begin
      status_upd <= upd_hit;
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_fault <= fault;
        rsp_wb    <= rd_ok && (req_dest != '0);
        rsp_data  <= rd_ok ? rd_val : '0;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_data) && $stable(rsp_wb) && $stable(rsp_fault)));

  assert_fault_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (!rsp_wb && (rsp_data == '0)));

  assert_upd_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_upd |-> $past(req_valid && req_ready && (req_op == 2'(OP_WRITE)) && !user_mode));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q[0] |-> !irq_req);
endmodule

// File: tb/ctl_regfile_bench.sv
module ctl_regfile_bench;
  localparam int          CLK_P  = 10;
  localparam logic [31:0] CPU_ID = 32'h0C1D_0042;

  logic        clk, rst_n;
  logic        req_valid, req_ready, user_mode;
  logic [1:0]  req_op;
  logic [4:0]  req_idx, req_dest;
  logic [31:0] req_wdata, irq_lines, rsp_data;
  logic        rsp_valid, rsp_ready, rsp_wb, rsp_fault, irq_req, status_upd;

  typedef struct {
    logic [31:0] data;
    logic        wb;
    logic        fault;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0, errors = 0;
  logic [31:0] m[32];
  bit          bp_mode = 0;
  int          bp_cnt = 0;
  bit          hold_prev = 0;
  logic [31:0] hold_data;

  ctl_regfile #(.CPU_ID(CPU_ID)) u_ctl_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_idx(req_idx), .req_dest(req_dest), .req_wdata(req_wdata),
    .user_mode(user_mode), .irq_lines(irq_lines), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_wb(rsp_wb),
    .rsp_fault(rsp_fault), .irq_req(irq_req), .status_upd(status_upd)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  initial rsp_ready = 1;
  always @(posedge clk) begin
    #2;
    bp_cnt++;
    rsp_ready = !bp_mode || (bp_cnt % 3 != 0);
  end

  // Storable index list from R4 / R2
  function automatic bit storable(int ix);
    case (ix)
      0, 1, 2, 3, 7, 8, 9, 10, 12, 13, 14, 15: return 1;
      default:                                 return 0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, int idx, logic [31:0] wd, int dest, bit user, string tag);
    exp_t e;
    bit   upd_exp;
    bit   irq_exp;
    @(negedge clk);
    req_op = op; req_idx = idx[4:0]; req_wdata = wd; req_dest = dest[4:0];
    user_mode = user; req_valid = 1;
    while (!req_ready) @(negedge clk);
    e.tag = tag; e.fault = 0; e.wb = 0; e.data = 0; upd_exp = 0;
    if (user && (op == 2'd0 || op == 2'd1)) e.fault = 1;
    else if (op == 2'd0) begin
      if (idx == 4)          e.data = irq_lines & m[3];
      else if (idx == 5)     e.data = CPU_ID;
      else if (storable(idx)) e.data = m[idx];
      e.wb = (dest != 0);
    end else if (op == 2'd1) begin
      if (storable(idx)) m[idx] = wd;
      upd_exp = (idx == 0) || (idx == 3);
    end else if (op == 2'd2) begin
      m[0] = m[1];
    end
    sb.push_back(e);
    @(posedge clk);
    #1 req_valid = 0;
    @(negedge clk);
    check(status_upd == upd_exp, "R6", "status_upd", 32'(status_upd), 32'(upd_exp));
    irq_exp = (|(irq_lines & m[3])) && m[0][0];
    check(irq_req == irq_exp, "R8", "irq_req", 32'(irq_req), 32'(irq_exp));
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      check(req_ready == (!rsp_valid || rsp_ready), "R9", "req_ready",
            32'(req_ready), 32'(!rsp_valid || rsp_ready));
      if (hold_prev)
        check(rsp_valid && rsp_data == hold_data, "R9", "held response",
              rsp_data, hold_data);
      hold_prev = rsp_valid && !rsp_ready;
      hold_data = rsp_data;
      if (rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          check(0, "R9", "unexpected response", rsp_data, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_data == e.data, e.tag, "rsp_data", rsp_data, e.data);
          check(rsp_wb == e.wb, e.tag, "rsp_wb", 32'(rsp_wb), 32'(e.wb));
          check(rsp_fault == e.fault, e.tag, "rsp_fault", 32'(rsp_fault), 32'(e.fault));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = 0;
    rst_n = 0; req_valid = 0; req_op = 0; req_idx = 0; req_dest = 0;
    req_wdata = 0; user_mode = 0; irq_lines = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!rsp_valid && !irq_req && !status_upd, "R1", "outputs after reset",
          {29'd0, rsp_valid, irq_req, status_upd}, 32'h0);
    check(req_ready, "R1", "req_ready after reset", 32'(req_ready), 32'h1);
    issue(0, 0, 0, 2, 0, "R1");
    issue(0, 1, 0, 2, 0, "R1");
    issue(0, 3, 0, 2, 0, "R1");

    // R2 store and read back
    issue(1, 1, 32'hA5A5_0006, 0, 0, "R2");
    issue(1, 3, 32'h0000_00F0, 0, 0, "R2");
    issue(1, 0, 32'h0000_0001, 0, 0, "R2");
    issue(1, 7, 32'h1234_5678, 0, 0, "R2");
    issue(1, 15, 32'hDEAD_BEEF, 0, 0, "R2");
    issue(0, 7, 0, 4, 0, "R2");
    issue(0, 15, 0, 4, 0, "R2");
    issue(0, 1, 0, 4, 0, "R2");

    // R3 / R8 pending masking
    irq_lines = 32'h0000_000F;
    issue(0, 4, 0, 3, 0, "R3");
    irq_lines = 32'h0000_0030;
    issue(0, 4, 0, 3, 0, "R3");
    issue(1, 4, 32'hFFFF_FFFF, 0, 0, "R3");
    issue(0, 3, 0, 3, 0, "R3");
    issue(0, 4, 0, 3, 0, "R3");
    issue(1, 0, 32'h0000_0000, 0, 0, "R8");
    issue(1, 0, 32'h0000_0001, 0, 0, "R8");
    irq_lines = 32'h8000_0000;
    issue(1, 3, 32'h8000_0000, 0, 0, "R8");

    // R4 constant and reserved
    issue(1, 5, 32'h1111_1111, 0, 0, "R4");
    issue(0, 5, 0, 6, 0, "R4");
    issue(1, 6, 32'h2222_2222, 0, 0, "R4");
    issue(1, 20, 32'h3333_3333, 0, 0, "R4");
    issue(0, 6, 0, 6, 0, "R4");
    issue(0, 20, 0, 6, 0, "R4");
    issue(0, 11, 0, 6, 0, "R4");

    // R5 user mode
    issue(1, 0, 32'h0000_0000, 0, 1, "R5");
    issue(0, 0, 0, 5, 1, "R5");
    issue(1, 7, 32'h0BAD_0BAD, 0, 1, "R5");
    issue(0, 0, 0, 5, 0, "R5");
    issue(0, 7, 0, 5, 0, "R5");

    // R7 exception return
    issue(1, 1, 32'h0000_0005, 0, 0, "R7");
    issue(1, 0, 32'h0000_0000, 0, 0, "R7");
    issue(2, 0, 0, 0, 0, "R7");
    issue(0, 0, 0, 9, 0, "R7");
    issue(3, 0, 32'hFFFF_FFFF, 0, 0, "R7");
    issue(0, 0, 0, 9, 0, "R7");

    // R10 destination zero
    issue(0, 1, 0, 0, 0, "R10");

    // R9 back-pressure
    bp_mode = 1;
    for (int i = 0; i < 12; i++) issue(0, (i % 2) ? 7 : 15, 0, 1, 0, "R9");
    issue(1, 8, 32'hCAFE_0008, 0, 0, "R9");
    issue(0, 8, 0, 1, 0, "R9");
    bp_mode = 0;

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule